// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core with Alarm

This block keeps the calendar time of a real-time clock: seconds, minutes, hours, day of the week, day of the month, month, two-digit year and century. It advances the time by one second after every `TICKS_PER_SEC` pulses of a timebase enable, normally a 32768 Hz tick. Each field is presented either in packed BCD or in plain binary, and hours in 24-hour or 12-hour form. In 12-hour form bit 7 of the hours byte marks the afternoon. The time is held internally in binary, so a change of mode takes effect at the outputs at once.

A status bit warns software that an update is about to happen during the last few timebase ticks of every second. At each update the block raises a one-cycle update-ended request. It also compares the new time with three alarm bytes and raises a one-cycle alarm request on a match. An alarm byte with its two top bits set matches any value of its field. A hold input freezes the time so that software can write it. A divider-reset code stops the prescaler, and the first update after release comes half a second later. The register file and the interrupt logic that consume the requests sit outside this block.

Top module: `rtc_clock_core`

## Requirements
- R1: With `bin_mode_i` = 1 every time byte and alarm byte is plain binary. With `bin_mode_i` = 0 it is packed BCD, tens in bits 7:4 and units in bits 3:0. This applies to the outputs, to written data and to alarm comparison.
- R2: With `hr24_i` = 1 the hours byte runs 0 to 23 and bit 7 is 0. With `hr24_i` = 0 the hours byte holds 12, 1, ..., 11 in bits 6:0 and bit 7 = 1 for afternoon hours, so internal hour 0 reads 12 with bit 7 = 0, and hour 12 reads 12 with bit 7 = 1.
- R3: The prescaler counts `tick_i` pulses, and the seconds advance on the tick that ends each run of `TICKS_PER_SEC` ticks. Seconds and minutes wrap from 59 to 0 and carry, and hours wrap from 23 to 0 and carry.
- R4: At midnight the day of the week (1 to 7) wraps from 7 to 1 and the date advances. A date past the month's length becomes 1 and the month advances. Month 12 wraps to 1 and the year advances. Year 99 wraps to 0 and the century advances, wrapping from 99 to 0.
- R5: February has 29 days when the full year (century*100 + year) is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28. April, June, September and November have 30 days, and the rest have 31.
- R6: `uip_o` is 1 exactly while the clock runs and the prescaler is within the last `UIP_TICKS` counts before an update. Otherwise it is 0.
- R7: While `set_hold_i` = 1 the time does not advance, `uip_o` = 0 and no update request is raised. In the cycle after `set_hold_i` rises, `uie_clr_o` pulses for one cycle.
- R8: While `div_ctl_i` = 2'b11 the prescaler is held at `TICKS_PER_SEC`/2, there are no updates or alarms, and `uip_o` = 0. After release the first update comes after `TICKS_PER_SEC`/2 ticks.
- R9: `uf_set_o` is a one-cycle pulse in the first cycle that shows the new time of each update.
- R10: `af_set_o` pulses with `uf_set_o` when each of the three alarm bytes (seconds, minutes, hours) either has bits 7:6 = 2'b11 or equals the field's output byte in the current modes.
- R11: A write with `wr_en_i` = 1 stores `wr_data_i` (decoded per R1 and R2) in the field chosen by `wr_sel_i`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hours. Other codes are ignored. A write in an update cycle replaces only its own field, and the other fields advance.
- R12: After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, century 20. The alarm bytes are 0x00, the prescaler is 0, and all requests are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase enable, one pulse per timebase period |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = packed BCD |
| hr24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag |
| set_hold_i | input | 1 | Freeze time for software setting |
| div_ctl_i | input | 2 | Divider control; 2'b11 holds the prescaler in reset |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 4 | Field select code for writes |
| wr_data_i | input | 8 | Write data in the current encoding |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Day-of-week byte |
| date_o | output | 8 | Day-of-month byte |
| month_o | output | 8 | Month byte |
| year_o | output | 8 | Year-in-century byte |
| cent_o | output | 8 | Century byte |
| uip_o | output | 1 | Update about to happen |
| uf_set_o | output | 1 | Update-ended request pulse |
| af_set_o | output | 1 | Alarm request pulse |
| uie_clr_o | output | 1 | Pulse asking to clear the update interrupt enable |

## Verification
A wrong prescaler count shows first at `uip_o`: the window opens or closes on the wrong cycle, one to eight ticks before the update moves. The seconds byte and `uf_set_o` then step on the wrong cycle. A wrong carry or month-length decision shows only at the second it fires, so the bench loads times a few seconds before each rollover: end of minute, end of day, end of a 30-day month and end of century. It covers February in a plain leap year, in a century year that is not a leap year and in one that is. A fault in the encoding paths shows in the same cycle as a mode change, because every output byte is derived again from the binary state.

// File: rtl/rtc_core_pkg.sv
// Shared types and pure conversion functions for the timekeeping core.
// Assumes binary internal storage; all functions are combinational.
package rtc_core_pkg;

    // Binary time of day and calendar, widths sized to the field ranges.
    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] month;
        logic [6:0] year;
        logic [6:0] cent;
    } rtc_time_t;

    // Field select codes on the write port.
    typedef enum logic [3:0] {
        FLD_SEC   = 4'd0,
        FLD_MIN   = 4'd1,
        FLD_HOUR  = 4'd2,
        FLD_DOW   = 4'd3,
        FLD_DATE  = 4'd4,
        FLD_MONTH = 4'd5,
        FLD_YEAR  = 4'd6,
        FLD_CENT  = 4'd7,
        FLD_ASEC  = 4'd8,
        FLD_AMIN  = 4'd9,
        FLD_AHOUR = 4'd10
    } fld_e;

    localparam rtc_time_t TIME_AT_RESET = '{6'd0, 6'd0, 5'd0, 3'd1, 5'd1, 4'd1, 7'd0, 7'd20};

    // Binary 0..99 to packed BCD.
    function automatic logic [7:0] bcd_enc(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v - tens * 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    // Packed BCD to binary.
    function automatic logic [6:0] bcd_dec(input logic [7:0] d);
        logic [6:0] tens;
        tens = {3'b000, d[7:4]};
        return (tens * 7'd10) + {3'b000, d[3:0]};
    endfunction

    // Binary value to output byte in the selected data mode.
    function automatic logic [7:0] field_enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : bcd_enc(v);
    endfunction

    // Written byte to binary value in the selected data mode.
    function automatic logic [6:0] field_dec(input logic [7:0] d, input logic bin);
        return bin ? d[6:0] : bcd_dec(d);
    endfunction

    // Internal hour 0..23 to hours byte in the selected data and hour modes.
    function automatic logic [7:0] hour_enc(input logic [4:0] h, input logic bin, input logic h24);
        logic [6:0] h7;
        logic [6:0] h12;
        logic       pm;
        logic [7:0] b;
        h7 = {2'b00, h};
        if (h24) begin
            return field_enc(h7, bin);
        end
        pm  = (h >= 5'd12);
        h12 = pm ? (h7 - 7'd12) : h7;
        if (h12 == 7'd0) h12 = 7'd12;
        b = field_enc(h12, bin);
        return {pm, b[6:0]};
    endfunction

    // Hours byte to internal hour 0..23.
    function automatic logic [4:0] hour_dec(input logic [7:0] d, input logic bin, input logic h24);
        logic [6:0] v;
        if (h24) begin
            v = field_dec(d, bin);
        end else begin
            v = field_dec({1'b0, d[6:0]}, bin);
            if (v == 7'd12) v = 7'd0;
            if (d[7]) v = v + 7'd12;
        end
        return v[4:0];
    endfunction

    // Length of the month; 100 is a multiple of 4, so the year's low bits
    // and the century's low bits decide the leap rule.
    function automatic logic [4:0] month_days(input logic [3:0] month, input logic [6:0] year,
                                              input logic [6:0] cent);
        logic leap;
        leap = (year[1:0] == 2'b00) && ((year != 7'd0) || (cent[1:0] == 2'b00));
        case (month)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
// Prescaler for the once-per-second update. Counts timebase ticks, flags the
// update tick and the update-warning window. Assumes TICKS_PER_SEC >= 2 and
// UIP_TICKS < TICKS_PER_SEC/2.
module rtc_timebase #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic div_rst_i,
    output logic upd_o,
    output logic uip_o
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] CNT_LAST  = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] CNT_HALF  = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] CNT_WARN  = CW'(TICKS_PER_SEC - UIP_TICKS);

    logic [CW-1:0] cnt_q;
    logic          running;

    // Clock runs unless frozen for setting or divider held in reset.
    always_comb running = !hold_i && !div_rst_i;

    // Prescaler: parked mid-second in divider reset, wraps at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (div_rst_i) begin
            cnt_q <= CNT_HALF;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Update strobe on the tick that closes the second.
    always_comb upd_o = running && tick_i && (cnt_q == CNT_LAST);

    // Warning window over the final counts before the update.
    always_comb uip_o = running && (cnt_q >= CNT_WARN);

    // R6: an update can only happen while the warning bit is shown.
    a_r6_update_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> uip_o);

    // R8: the cycle after divider reset ends cannot be an update.
    a_r8_no_update_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst_i |=> !upd_o);

    // R6: the warning bit never rises mid-window; it opens from a lower count.
    a_r6_window_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_rst_i && !uip_o && !hold_i) |=> (!uip_o || cnt_q == CNT_WARN || hold_i || div_rst_i));

endmodule

// File: rtl/rtc_calendar.sv
// Time-of-day and calendar registers in binary. Advances one second per
// update strobe with full carry and leap-year handling, and takes field
// writes decoded from the current data and hour modes. A write in an update
// cycle replaces its own field after the advance.
module rtc_calendar
    import rtc_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic       bin_i,
    input  logic       h24_i,
    output rtc_time_t  time_o
);
    rtc_time_t  time_q;
    rtc_time_t  adv;
    rtc_time_t  nxt;
    logic [4:0] mdays;
    logic [6:0] wval;
    logic [4:0] whour;

    // Length of the current month.
    always_comb mdays = month_days(time_q.month, time_q.year, time_q.cent);

    // One-second advance with the carry chain through to the century.
    always_comb begin
        adv = time_q;
        if (time_q.sec != 6'd59) begin
            adv.sec = time_q.sec + 6'd1;
        end else begin
            adv.sec = 6'd0;
            if (time_q.min != 6'd59) begin
                adv.min = time_q.min + 6'd1;
            end else begin
                adv.min = 6'd0;
                if (time_q.hour != 5'd23) begin
                    adv.hour = time_q.hour + 5'd1;
                end else begin
                    adv.hour = 5'd0;
                    adv.dow  = (time_q.dow >= 3'd7) ? 3'd1 : time_q.dow + 3'd1;
                    if (time_q.date < mdays) begin
                        adv.date = time_q.date + 5'd1;
                    end else begin
                        adv.date = 5'd1;
                        if (time_q.month < 4'd12) begin
                            adv.month = time_q.month + 4'd1;
                        end else begin
                            adv.month = 4'd1;
                            if (time_q.year < 7'd99) begin
                                adv.year = time_q.year + 7'd1;
                            end else begin
                                adv.year = 7'd0;
                                adv.cent = (time_q.cent >= 7'd99) ? 7'd0 : time_q.cent + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // Next state: advance on update, then overlay any field write.
    always_comb begin
        wval  = field_dec(wr_data_i, bin_i);
        whour = hour_dec(wr_data_i, bin_i, h24_i);
        nxt   = upd_i ? adv : time_q;
        if (wr_en_i) begin
            case (wr_sel_i)
                FLD_SEC:   nxt.sec   = wval[5:0];
                FLD_MIN:   nxt.min   = wval[5:0];
                FLD_HOUR:  nxt.hour  = whour;
                FLD_DOW:   nxt.dow   = wval[2:0];
                FLD_DATE:  nxt.date  = wval[4:0];
                FLD_MONTH: nxt.month = wval[3:0];
                FLD_YEAR:  nxt.year  = wval;
                FLD_CENT:  nxt.cent  = wval;
                default:   ;
            endcase
        end
    end

    // Time register.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= TIME_AT_RESET;
        else        time_q <= nxt;
    end

    always_comb time_o = time_q;

    // R3: an update without a write steps the seconds by one, modulo 60.
    a_r3_second_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_en_i) |=>
        (time_q.sec == (($past(time_q.sec) == 6'd59) ? 6'd0 : $past(time_q.sec) + 6'd1)));

    // R4: an update keeps a valid date valid and non-zero.
    a_r4_date_in_month: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_en_i && time_q.date != 5'd0 && time_q.date <= mdays) |=>
        (time_q.date != 5'd0 && time_q.date <= month_days(time_q.month, time_q.year, time_q.cent)));

    // R11: with neither update nor write the time holds.
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !wr_en_i) |=> $stable(time_q));

endmodule

// File: rtl/rtc_alarm.sv
// Alarm bytes and match logic. Each byte is compared with the field's output
// byte in the current modes; a byte with bits 7:6 both set matches anything.
// The alarm request fires only together with the update-ended request.
module rtc_alarm
    import rtc_core_pkg::*;
#(
    parameter int NUM_FIELDS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [3:0]                 wr_sel_i,
    input  logic [7:0]                 wr_data_i,
    input  logic [NUM_FIELDS-1:0][7:0] now_i,
    input  logic                       upd_done_i,
    output logic                       af_o
);
    logic [7:0]            alarm_q [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hit;
    logic [NUM_FIELDS-1:0] wild;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam logic [3:0] SEL = 4'(int'(FLD_ASEC) + g);

        // Alarm byte register, written raw in the current encoding.
        always_ff @(posedge clk) begin
            if (!rst_n)                               alarm_q[g] <= 8'h00;
            else if (wr_en_i && (wr_sel_i == SEL))    alarm_q[g] <= wr_data_i;
        end

        assign wild[g] = (alarm_q[g][7:6] == 2'b11);
        assign hit[g]  = wild[g] || (alarm_q[g] == now_i[g]);
    end

    // Alarm request with the update that produced the matching time.
    always_comb af_o = upd_done_i && (&hit);

    // R10: no alarm request outside an update-ended pulse.
    a_r10_alarm_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        af_o |-> upd_done_i);

    // R10: all-wildcard alarm fires at every update.
    a_r10_wildcard_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done_i && (&wild)) |-> af_o);

endmodule

// File: rtl/rtc_clock_core.sv
// Top of the timekeeping core: prescaler, calendar, alarm and output
// encoding. Requests are registered one-cycle pulses aligned with the first
// cycle that shows the new time. Assumes tick_i is synchronous to clk.
module rtc_clock_core
    import rtc_core_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bin_mode_i,
    input  logic       hr24_i,
    input  logic       set_hold_i,
    input  logic [1:0] div_ctl_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o,
    output logic       uip_o,
    output logic       uf_set_o,
    output logic       af_set_o,
    output logic       uie_clr_o
);
    localparam int ALARM_FIELDS = 3;

    logic                         div_rst;
    logic                         upd;
    logic                         uf_q;
    logic                         hold_q;
    logic                         uie_q;
    rtc_time_t                    cal_time;
    logic [ALARM_FIELDS-1:0][7:0] alarm_view;

    // Divider reset code.
    always_comb div_rst = (div_ctl_i == 2'b11);

    rtc_timebase #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .hold_i    (set_hold_i),
        .div_rst_i (div_rst),
        .upd_o     (upd),
        .uip_o     (uip_o)
    );

    rtc_calendar u_calendar (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (upd),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .bin_i     (bin_mode_i),
        .h24_i     (hr24_i),
        .time_o    (cal_time)
    );

    // Output bytes re-encoded from binary state in the current modes.
    always_comb begin
        sec_o   = field_enc({1'b0, cal_time.sec}, bin_mode_i);
        min_o   = field_enc({1'b0, cal_time.min}, bin_mode_i);
        hour_o  = hour_enc(cal_time.hour, bin_mode_i, hr24_i);
        dow_o   = field_enc({4'b0000, cal_time.dow}, bin_mode_i);
        date_o  = field_enc({2'b00, cal_time.date}, bin_mode_i);
        month_o = field_enc({3'b000, cal_time.month}, bin_mode_i);
        year_o  = field_enc(cal_time.year, bin_mode_i);
        cent_o  = field_enc(cal_time.cent, bin_mode_i);
    end

    always_comb alarm_view = {hour_o, min_o, sec_o};

    rtc_alarm #(
        .NUM_FIELDS (ALARM_FIELDS)
    ) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .now_i      (alarm_view),
        .upd_done_i (uf_q),
        .af_o       (af_set_o)
    );

    // Request pulses: update-ended and enable-clear on the rise of hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q   <= 1'b0;
            hold_q <= 1'b0;
            uie_q  <= 1'b0;
        end else begin
            uf_q   <= upd;
            hold_q <= set_hold_i;
            uie_q  <= set_hold_i && !hold_q;
        end
    end

    always_comb uf_set_o  = uf_q;
    always_comb uie_clr_o = uie_q;

    // R7: holding freezes the calendar unless software writes it.
    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold_i && !wr_en_i) |=> $stable(cal_time));

    // R7: no update-ended request from a held cycle.
    a_r7_no_uf_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        set_hold_i |=> !uf_set_o);

    // R9: update-ended request lasts exactly one cycle.
    a_r9_uf_single: assert property (@(posedge clk) disable iff (!rst_n)
        uf_set_o |=> !uf_set_o);

    // R7: enable-clear request lasts exactly one cycle.
    a_r7_uie_single: assert property (@(posedge clk) disable iff (!rst_n)
        uie_clr_o |=> !uie_clr_o);

endmodule

// File: tb/rtc_clock_core_tb_top.sv
// Self-checking bench: a behavioural model in integers is stepped on every
// rising edge and all outputs are compared on every falling edge.
module rtc_clock_core_tb_top;
    localparam int TPS  = 64;
    localparam int UIPT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bin_mode = 1'b0;
    logic       hr24 = 1'b1;
    logic       set_hold = 1'b0;
    logic [1:0] div_ctl = 2'b00;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;
    logic       uip_o, uf_set_o, af_set_o, uie_clr_o;

    rtc_clock_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bin_mode_i(bin_mode), .hr24_i(hr24),
        .set_hold_i(set_hold), .div_ctl_i(div_ctl), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o), .uip_o(uip_o),
        .uf_set_o(uf_set_o), .af_set_o(af_set_o), .uie_clr_o(uie_clr_o));

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";
    bit    done = 1'b0;

    // Model state.
    int m_cnt = 0, m_sec = 0, m_min = 0, m_hour = 0, m_dow = 1, m_date = 1, m_month = 1;
    int m_year = 0, m_cent = 20;
    int m_al[3] = '{0, 0, 0};
    int m_uf = 0, m_uie = 0, m_hold_q = 0;

    function automatic int enc(int v);
        return bin_mode ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dec(int d);
        return bin_mode ? (d & 127) : ((d >> 4) * 10 + (d & 15));
    endfunction

    function automatic int henc(int h);
        int hh;
        if (hr24) return enc(h);
        hh = h % 12;
        if (hh == 0) hh = 12;
        return enc(hh) | ((h >= 12) ? 128 : 0);
    endfunction

    function automatic int hdec(int d);
        int h;
        if (hr24) return dec(d);
        h = dec(d & 127) % 12;
        if ((d & 128) != 0) h = h + 12;
        return h;
    endfunction

    function automatic int mdays(int mo, int yr, int ce);
        int full;
        bit leap;
        full = ce * 100 + yr;
        leap = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Model step at the same edge the design samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1;
            m_month = 1; m_year = 0; m_cent = 20;
            m_al[0] = 0; m_al[1] = 0; m_al[2] = 0;
            m_uf = 0; m_uie = 0; m_hold_q = 0;
        end else begin
            bit divr;
            bit upd;
            divr = (div_ctl == 2'b11);
            upd  = tick && (m_cnt == TPS - 1) && !divr && !set_hold;
            if (divr) m_cnt = TPS / 2;
            else if (tick) m_cnt = (m_cnt == TPS - 1) ? 0 : m_cnt + 1;
            if (upd) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hour++;
                        if (m_hour == 24) begin
                            m_hour = 0;
                            m_dow = (m_dow % 7) + 1;
                            m_date++;
                            if (m_date > mdays(m_month, m_year, m_cent)) begin
                                m_date = 1; m_month++;
                                if (m_month == 13) begin
                                    m_month = 1; m_year++;
                                    if (m_year == 100) begin
                                        m_year = 0;
                                        m_cent = (m_cent + 1) % 100;
                                    end
                                end
                            end
                        end
                    end
                end
            end
            if (wr_en) begin
                case (int'(wr_sel))
                    0: m_sec = dec(wr_data);
                    1: m_min = dec(wr_data);
                    2: m_hour = hdec(wr_data);
                    3: m_dow = dec(wr_data);
                    4: m_date = dec(wr_data);
                    5: m_month = dec(wr_data);
                    6: m_year = dec(wr_data);
                    7: m_cent = dec(wr_data);
                    8: m_al[0] = int'(wr_data);
                    9: m_al[1] = int'(wr_data);
                    10: m_al[2] = int'(wr_data);
                    default: ;
                endcase
            end
            m_uf = upd;
            m_uie = (set_hold && (m_hold_q == 0)) ? 1 : 0;
            m_hold_q = set_hold;
        end
    end

    task automatic chk(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    function automatic bit amatch(int a, int cur);
        return ((a & 8'hC0) == 8'hC0) || (a == cur);
    endfunction

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            int exp_uip;
            int exp_af;
            exp_uip = (!set_hold && div_ctl != 2'b11 && m_cnt >= TPS - UIPT) ? 1 : 0;
            exp_af  = (m_uf != 0 && amatch(m_al[0], enc(m_sec)) && amatch(m_al[1], enc(m_min))
                       && amatch(m_al[2], henc(m_hour))) ? 1 : 0;
            chk("sec", int'(sec_o), enc(m_sec));
            chk("min", int'(min_o), enc(m_min));
            chk("hour", int'(hour_o), henc(m_hour));
            chk("dow", int'(dow_o), enc(m_dow));
            chk("date", int'(date_o), enc(m_date));
            chk("month", int'(month_o), enc(m_month));
            chk("year", int'(year_o), enc(m_year));
            chk("cent", int'(cent_o), enc(m_cent));
            chk("uip", int'(uip_o), exp_uip);
            chk("uf_set", int'(uf_set_o), m_uf);
            chk("af_set", int'(af_set_o), exp_af);
            chk("uie_clr", int'(uie_clr_o), m_uie);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 8'(data);
        step(1);
        wr_en = 1'b0;
    endtask

    // Load a full time with the timebase paused.
    task automatic set_time(int h, int mi, int s, int dw, int dt, int mo, int yr, int ce);
        bit t;
        t = tick; tick = 1'b0;
        wr(0, enc(s)); wr(1, enc(mi)); wr(2, henc(h)); wr(3, enc(dw));
        wr(4, enc(dt)); wr(5, enc(mo)); wr(6, enc(yr)); wr(7, enc(ce));
        tick = t;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        step(3);
        tag = "R12";
        rst_n = 1'b1;
        step(4);
        // R3 / R6 / R9: free-running seconds in BCD 24-hour mode.
        tag = "R3";
        tick = 1'b1;
        step(TPS * 3 + 5);
        tag = "R6";
        step(TPS + 3);
        // R3 with irregular ticks.
        tag = "R3";
        repeat (TPS * 4) begin
            tick = 1'($urandom_range(0, 1));
            step(1);
        end
        tick = 1'b1;
        // R4: end of century rollover, day of week 7 to 1.
        tag = "R4";
        set_time(23, 59, 58, 7, 31, 12, 99, 20);
        step(TPS * 3);
        tag = "R4";
        set_time(23, 59, 59, 3, 30, 4, 7, 20);
        step(TPS * 2);
        // R5: leap rules.
        tag = "R5";
        set_time(23, 59, 59, 2, 28, 2, 24, 20);
        step(TPS * 2);
        set_time(23, 59, 59, 2, 28, 2, 0, 21);
        step(TPS * 2);
        set_time(23, 59, 59, 2, 28, 2, 0, 20);
        step(TPS * 2);
        set_time(23, 59, 59, 2, 29, 2, 24, 20);
        step(TPS * 2);
        set_time(23, 59, 59, 2, 28, 2, 23, 20);
        step(TPS * 2);
        // R1: binary mode.
        tag = "R1";
        bin_mode = 1'b1;
        step(3);
        set_time(22, 59, 57, 5, 15, 6, 45, 20);
        step(TPS * 4);
        // R2: 12-hour mode in binary and BCD.
        tag = "R2";
        hr24 = 1'b0;
        step(2);
        set_time(23, 59, 58, 1, 10, 3, 30, 20);
        step(TPS * 3);
        bin_mode = 1'b0;
        step(2);
        set_time(11, 59, 58, 1, 10, 3, 30, 20);
        step(TPS * 3);
        set_time(12, 59, 59, 1, 10, 3, 30, 20);
        step(TPS * 2);
        hr24 = 1'b1;
        step(2);
        // R10: alarms with wildcards and with a full match.
        tag = "R10";
        tick = 1'b0;
        wr(8, enc(5)); wr(9, 8'hC0); wr(10, 8'hFF);
        set_time(0, 0, 0, 1, 1, 1, 10, 20);
        step(TPS * 8);
        tick = 1'b0;
        wr(8, enc(2)); wr(9, enc(0)); wr(10, henc(1));
        set_time(0, 59, 58, 1, 1, 1, 10, 20);
        step(TPS * 6);
        tick = 1'b0;
        wr(8, 8'hC3); wr(9, 8'hC0); wr(10, 8'hC0);
        tick = 1'b1;
        step(TPS * 3);
        tick = 1'b0;
        wr(8, 8'h00); wr(9, 8'h00); wr(10, 8'h00);
        tick = 1'b1;
        // R7: hold freezes time and pulses the enable clear.
        tag = "R7";
        set_hold = 1'b1;
        step(TPS * 2 + 7);
        wr(0, enc(40));
        step(5);
        set_hold = 1'b0;
        step(TPS * 2);
        // R8: divider reset and half-second restart.
        tag = "R8";
        div_ctl = 2'b11;
        step(TPS + 11);
        div_ctl = 2'b10;
        step(TPS * 2);
        // R11: write coinciding with an update, and an ignored code.
        tag = "R11";
        while (m_cnt != TPS - 1) step(1);
        wr(1, enc(30));
        step(TPS);
        wr(12, 8'h55);
        wr(15, 8'h11);
        step(TPS * 2);
        // R12: reset mid-run returns to the reset state.
        tag = "R12";
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        tick = 1'b0;
        step(4);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog: actual timeout expected completion", tag);
            finish_run();
        end
    end

endmodule